// File: doc/BRIEF.md
# Multi-mode ADC conversion sequencer

This block is the control logic that sits in front of a 16-input multiplexed successive-approximation converter. Software programs a control register with a mode, a channel and a few option bits. The sequencer then picks the channel and issues start pulses to an abstract converter core, which answers with a one-cycle done strobe and a 10-bit code. Each normal result is placed in a result register, tagged with its channel number, and an interrupt pulse is raised.

There are four modes. Single-once converts one channel one time. Single-repeat converts the same channel over and over. Scan-once converts every channel from the programmed top channel down to channel 0. Scan-repeat does the same and wraps back to the top channel after channel 0.

A result that arrives before software has read the previous one is handled in one of two ways, chosen by a control bit. The block either overwrites the old result and pulses an overrun interrupt, or it parks the new result in a one-entry buffer and stops issuing conversions until the result register has been read. While a repeating mode runs, software may request one injected conversion of any channel. That conversion is served between two normal ones, and its result goes to a second result register. The normal sequence is not disturbed by it.

Top module: `adc_seq`

## Requirements
- R1: After reset the outputs are all 0. Reads of the control register (address 0), the result register (address 1) and the injected result register (address 2) all return 0.
- R2: The control register is written at address 0. Its fields are: top channel in [3:0]; mode in [5:4] (00 single-once, 01 single-repeat, 10 scan-once, 11 scan-repeat); run bit in [6]; wait-for-read in [7]; inject request in [8]; inject channel in [15:12]. In single-once mode, setting the run bit converts the top channel exactly once and then clears the run bit.
- R3: In single-repeat mode the same channel is converted again and again. Writing the run bit to 0 lets the conversion in flight complete, and no further conversion starts after it.
- R4: In scan-once mode the channels are converted from the top channel down to channel 0, one conversion each, and then the sequencer stops.
- R5: In scan-repeat mode, channel 0 is followed by the top channel again.
- R6: When wait-for-read is 0 and a normal result completes while the result register is still full, the new result overwrites the old one. An overrun interrupt pulse is raised in the same cycle as the result interrupt.
- R7: When wait-for-read is 1 and a normal result completes while the result register is full, the new result is buffered. No overrun is raised and no new conversion starts. A read of the result register then moves the buffered value into it and raises a result interrupt one cycle after the read.
- R8: The result register reads as channel in [15:12], full flag in [11] and code in [9:0]. A read at address 1 clears the full flag unless a buffered result replaces it.
- R9: While a repeating mode runs, a control write with bit 8 set queues one conversion of the inject channel. It is started after the conversion in flight. Its result appears at address 2 as channel in [15:12] and code in [9:0], with an inject interrupt pulse. The normal channel sequence then resumes where it left off.
- R10: An inject request written while no repeating mode is running is ignored: no injected conversion is made and address 2 keeps its value.
- R11: Control bit [9] on read (busy) is 1 while the run bit is set, a conversion is in flight, a result is held back or an injection is queued, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; has side effects at address 1 |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the addressed register, combinational |
| conv_start | output | 1 | One-cycle start pulse to the converter core |
| conv_ch | output | 4 | Channel for the conversion being started |
| conv_done | input | 1 | One-cycle completion strobe from the converter core |
| conv_data | input | 10 | Conversion code, valid with conv_done |
| irq_result | output | 1 | Pulse: the result register received a value |
| irq_overrun | output | 1 | Pulse: an unread result was overwritten |
| irq_inject | output | 1 | Pulse: the injected result register received a value |

## Verification
Every mode is run with results read as soon as the interrupt fires. The order of channels tells the single modes apart from the scan modes and from the wrap-around, and the start count after stopping shows whether the conversion in flight was allowed to finish. The result register is also left unread under each overrun policy: the error policy must overwrite and flag, while the waiting policy must stall the start count and release the buffered value one read at a time. An injection is requested in the middle of a repeating scan, where the resumed channel order shows that the sequence was kept. The same request in single mode shows that it is ignored.

// File: rtl/adc_seq.sv
module adc_seq #(
  parameter int CH_W  = 4,
  parameter int RES_W = 10,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [1:0]       addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             conv_start,
  output logic [CH_W-1:0]  conv_ch,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data,
  output logic             irq_result,
  output logic             irq_overrun,
  output logic             irq_inject
);
  localparam int GAP = DW - CH_W - 1 - RES_W;
  localparam int GAP2 = DW - CH_W - RES_W;

  logic [CH_W-1:0]  top_ch, cur_ch, inj_ch, res_ch, buf_ch, r2_ch;
  logic [RES_W-1:0] res_val, buf_val, r2_val;
  logic [1:0]       mode;
  logic             go, wait_rd, inj_pend, conv_active, conv_is_inj;
  logic             res_full, hold, busy;

  wire wr_ctrl  = wr_en && addr == 2'd0;
  wire rd_res   = rd_en && addr == 2'd1;
  wire launch   = !conv_active && !hold && (inj_pend || go);
  wire finish   = conv_active && conv_done;
  wire full_now = res_full && !rd_res;
  wire unused_wbits = ^wdata[11:9];

  assign busy = go | conv_active | hold | inj_pend;

  always_comb begin
    case (addr)
      2'd0:    rdata = {inj_ch, 2'b00, busy, inj_pend, wait_rd, go, mode, top_ch};
      2'd1:    rdata = {res_ch, res_full, {GAP{1'b0}}, res_val};
      2'd2:    rdata = {r2_ch, {GAP2{1'b0}}, r2_val};
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_ch <= '0; cur_ch <= '0; inj_ch <= '0; mode <= '0;
      go <= 1'b0; wait_rd <= 1'b0; inj_pend <= 1'b0;
      conv_active <= 1'b0; conv_is_inj <= 1'b0; conv_start <= 1'b0; conv_ch <= '0;
      res_ch <= '0; res_val <= '0; res_full <= 1'b0;
      buf_ch <= '0; buf_val <= '0; hold <= 1'b0;
      r2_ch <= '0; r2_val <= '0;
      irq_result <= 1'b0; irq_overrun <= 1'b0; irq_inject <= 1'b0;
    end else begin
      conv_start  <= 1'b0;
      irq_result  <= 1'b0;
      irq_overrun <= 1'b0;
      irq_inject  <= 1'b0;

      if (rd_res) begin
        if (hold) begin
          res_ch     <= buf_ch;
          res_val    <= buf_val;
          hold       <= 1'b0;
          irq_result <= 1'b1;
        end else begin
          res_full <= 1'b0;
        end
      end

      if (launch) begin
        conv_start  <= 1'b1;
        conv_active <= 1'b1;
        conv_is_inj <= inj_pend;
        conv_ch     <= inj_pend ? inj_ch : cur_ch;
        inj_pend    <= 1'b0;
      end

      if (finish) begin
        conv_active <= 1'b0;
        if (conv_is_inj) begin
          r2_ch      <= conv_ch;
          r2_val     <= conv_data;
          irq_inject <= 1'b1;
        end else begin
          if (full_now && wait_rd) begin
            buf_ch  <= conv_ch;
            buf_val <= conv_data;
            hold    <= 1'b1;
          end else begin
            res_ch      <= conv_ch;
            res_val     <= conv_data;
            res_full    <= 1'b1;
            irq_result  <= 1'b1;
            irq_overrun <= full_now;
          end
          case (mode)
            2'b00: go <= 1'b0;
            2'b01: ;
            2'b10: if (cur_ch == '0) go <= 1'b0; else cur_ch <= cur_ch - 1'b1;
            2'b11: cur_ch <= (cur_ch == '0) ? top_ch : cur_ch - 1'b1;
          endcase
        end
      end

      if (wr_ctrl) begin
        top_ch  <= wdata[CH_W-1:0];
        mode    <= wdata[5:4];
        go      <= wdata[6];
        wait_rd <= wdata[7];
        inj_ch  <= wdata[DW-1 -: CH_W];
        if (wdata[6] && !go) cur_ch <= wdata[CH_W-1:0];
        if (wdata[8] && wdata[6] && wdata[4] && go) inj_pend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int CH_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            conv_start,
  input logic            irq_result,
  input logic            irq_overrun,
  input logic            irq_inject,
  input logic            busy,
  input logic            wait_rd,
  input logic            hold,
  input logic [CH_W-1:0] cur_ch
);
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);                                   // R2
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy);                                          // R11
  AST_OVR_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_overrun |-> irq_result);                                   // R6
  AST_NO_OVR_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_overrun |-> !$past(wait_rd));                              // R7
  AST_NO_START_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !conv_start);                                         // R7
  AST_INJ_KEEPS_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    irq_inject |-> $stable(cur_ch));                               // R9
  AST_IRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_inject && irq_result));                                  // R9
endmodule

bind adc_seq adc_seq_chk #(.CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .irq_result(irq_result),
  .irq_overrun(irq_overrun), .irq_inject(irq_inject), .busy(busy),
  .wait_rd(wait_rd), .hold(hold), .cur_ch(cur_ch)
);

// File: tb/adc_seq_tb.sv
`timescale 1ns/1ps
module adc_seq_tb;
  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        conv_start;
  logic [3:0]  conv_ch;
  logic        conv_done;
  logic [9:0]  conv_data;
  logic        irq_result, irq_overrun, irq_inject;

  int checks = 0, failures = 0, starts = 0, ovr_cnt = 0;
  int pend = 0;
  logic [3:0] lat_ch = '0;
  logic [15:0] res_q[$];
  logic [15:0] inj_q[$];

  always #5 clk = ~clk;

  adc_seq u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .conv_start(conv_start), .conv_ch(conv_ch),
    .conv_done(conv_done), .conv_data(conv_data), .irq_result(irq_result),
    .irq_overrun(irq_overrun), .irq_inject(irq_inject)
  );

  function automatic logic [9:0] model_val(input logic [3:0] ch);
    return 10'(int'(ch) * 61 + 7);
  endfunction
  function automatic logic [15:0] exp_res(input logic [3:0] ch);
    return {ch, 2'b10, model_val(ch)};
  endfunction
  function automatic logic [15:0] exp_inj(input logic [3:0] ch);
    return {ch, 2'b00, model_val(ch)};
  endfunction

  // converter core model
  initial begin
    conv_done = 1'b0;
    conv_data = '0;
    forever begin
      @(posedge clk);
      conv_done <= (pend == 1);
      if (pend == 1) conv_data <= model_val(lat_ch);
      if (conv_start) begin
        pend   <= LAT;
        lat_ch <= conv_ch;
        starts <= starts + 1;
      end else if (pend != 0) pend <= pend - 1;
    end
  end

  initial forever begin
    @(negedge clk);
    if (irq_overrun) ovr_cnt++;
  end

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [3:0] top, input logic [1:0] md, input bit g,
                         input bit wt, input bit inj, input logic [3:0] ich);
    @(negedge clk);
    addr = 2'd0; wdata = {ich, 3'b000, inj, wt, g, md, top}; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic consume(output logic [15:0] v);
    addr = 2'd1; #1; v = rdata;
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops expected items as the design raises interrupts
  task automatic monitor(input int n, input string tag);
    int got = 0;
    logic [15:0] v, e;
    while (got < n) begin
      @(negedge clk);
      if (irq_inject) begin
        peek(2'd2, v);
        if (inj_q.size() == 0) check(1'b0, "R10 unexpected injection", v, 16'h0);
        else begin e = inj_q.pop_front(); check(v == e, "R9 injected result", v, e); end
      end else if (irq_result) begin
        e = (res_q.size() != 0) ? res_q.pop_front() : 16'hxxxx;
        consume(v);
        check(v === e, tag, v, e);
        got++;
      end
    end
  endtask

  initial begin
    logic [15:0] v;
    int s0, o0;
    repeat (3) @(negedge clk);
    check(conv_start == 0 && irq_result == 0 && irq_overrun == 0 && irq_inject == 0,
          "R1 outputs after reset", {12'h0, conv_start, irq_result, irq_overrun, irq_inject}, 16'h0);
    peek(2'd0, v); check(v == 16'h0, "R1 control reset", v, 16'h0);
    peek(2'd1, v); check(v == 16'h0, "R1 result reset", v, 16'h0);
    peek(2'd2, v); check(v == 16'h0, "R1 inject result reset", v, 16'h0);
    rst_n = 1'b1;
    idle(2);

    // R2 single-once, R11 busy, R8 clear on read
    s0 = starts;
    res_q.push_back(exp_res(4'd7));
    wr_ctrl(4'd7, 2'b00, 1, 0, 0, 4'd0);
    peek(2'd0, v); check(v[9] == 1'b1, "R11 busy after run", {15'h0, v[9]}, 16'h1);
    monitor(1, "R2 single-once result");
    peek(2'd1, v); check(v[11] == 1'b0, "R8 full cleared by read", {15'h0, v[11]}, 16'h0);
    idle(20);
    check(starts - s0 == 1, "R2 one conversion", 16'(starts - s0), 16'd1);
    peek(2'd0, v); check(v[6] == 1'b0 && v[9] == 1'b0, "R11 idle after single-once", {14'h0, v[9], v[6]}, 16'h0);

    // R3 single-repeat with stop
    s0 = starts;
    repeat (4) res_q.push_back(exp_res(4'd11));
    wr_ctrl(4'd11, 2'b01, 1, 0, 0, 4'd0);
    monitor(3, "R3 repeat result");
    wr_ctrl(4'd11, 2'b01, 0, 0, 0, 4'd0);
    monitor(1, "R3 in-flight result after stop");
    idle(20);
    check(starts - s0 == 4, "R3 no start after stop", 16'(starts - s0), 16'd4);
    peek(2'd0, v); check(v[9] == 1'b0, "R11 idle after stop", {15'h0, v[9]}, 16'h0);

    // R4 scan-once
    s0 = starts;
    for (int c = 3; c >= 0; c--) res_q.push_back(exp_res(4'(c)));
    wr_ctrl(4'd3, 2'b10, 1, 0, 0, 4'd0);
    monitor(4, "R4 scan-once order");
    idle(20);
    check(starts - s0 == 4, "R4 scan stops after channel 0", 16'(starts - s0), 16'd4);

    // R5 scan-repeat wrap with R9 injection in the middle
    s0 = starts;
    res_q.push_back(exp_res(4'd3)); res_q.push_back(exp_res(4'd2));
    res_q.push_back(exp_res(4'd1)); res_q.push_back(exp_res(4'd0));
    res_q.push_back(exp_res(4'd3)); res_q.push_back(exp_res(4'd2));
    wr_ctrl(4'd3, 2'b11, 1, 0, 0, 4'd0);
    monitor(2, "R5 scan-repeat order");
    inj_q.push_back(exp_inj(4'd9));
    wr_ctrl(4'd3, 2'b11, 1, 0, 1, 4'd9);
    monitor(4, "R5 R9 order kept around injection");
    check(inj_q.size() == 0, "R9 injection served", 16'(inj_q.size()), 16'd0);
    res_q.push_back(exp_res(4'd1));
    wr_ctrl(4'd3, 2'b11, 0, 0, 0, 4'd0);
    monitor(1, "R5 last result after stop");
    idle(20);
    check(starts - s0 == 8, "R9 start count with injection", 16'(starts - s0), 16'd8);
    peek(2'd2, v); check(v == exp_inj(4'd9), "R9 inject register", v, exp_inj(4'd9));

    // R10 inject request ignored in single-once mode
    s0 = starts;
    res_q.push_back(exp_res(4'd6));
    wr_ctrl(4'd6, 2'b00, 1, 0, 1, 4'd12);
    monitor(1, "R10 single result");
    idle(20);
    check(starts - s0 == 1, "R10 no extra conversion", 16'(starts - s0), 16'd1);
    peek(2'd2, v); check(v == exp_inj(4'd9), "R10 inject register kept", v, exp_inj(4'd9));

    // R6 overrun with wait-for-read off
    wr_ctrl(4'd2, 2'b01, 1, 0, 0, 4'd0);
    do @(negedge clk); while (!irq_result);
    check(irq_overrun == 1'b0, "R6 no overrun on first result", {15'h0, irq_overrun}, 16'h0);
    do @(negedge clk); while (!irq_result);
    check(irq_overrun == 1'b1, "R6 overrun on unread result", {15'h0, irq_overrun}, 16'h1);
    wr_ctrl(4'd2, 2'b01, 0, 0, 0, 4'd0);
    idle(20);
    consume(v); check(v == exp_res(4'd2), "R6 overwritten value", v, exp_res(4'd2));

    // R7 hold until read
    s0 = starts; o0 = ovr_cnt;
    wr_ctrl(4'd2, 2'b10, 1, 1, 0, 4'd0);
    idle(60);
    check(starts - s0 == 2, "R7 stall while held", 16'(starts - s0), 16'd2);
    peek(2'd0, v); check(v[9] == 1'b1, "R11 busy while held", {15'h0, v[9]}, 16'h1);
    consume(v); check(v == exp_res(4'd2), "R7 first result kept", v, exp_res(4'd2));
    check(irq_result == 1'b1, "R7 result irq after read", {15'h0, irq_result}, 16'h1);
    peek(2'd1, v); check(v == exp_res(4'd1), "R7 buffered value moved", v, exp_res(4'd1));
    idle(60);
    check(starts - s0 == 3, "R7 resumed once", 16'(starts - s0), 16'd3);
    consume(v); check(v == exp_res(4'd1), "R7 second read", v, exp_res(4'd1));
    consume(v); check(v == exp_res(4'd0), "R7 third read", v, exp_res(4'd0));
    peek(2'd1, v); check(v[11] == 1'b0, "R8 full cleared at end", {15'h0, v[11]}, 16'h0);
    check(ovr_cnt == o0, "R7 no overrun in wait mode", 16'(ovr_cnt - o0), 16'd0);
    peek(2'd0, v); check(v[9] == 1'b0, "R11 idle after held scan", {15'h0, v[9]}, 16'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule